// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block wraps a small synchronous memory array with the control and data path of a pipelined burst SRAM. On every rising clock edge it captures the chip enables, the two address strobes (a processor-side strobe and a controller-side strobe), the advance input, the write controls, the address and the write data. It decodes that cycle into one of four actions: a read, a write, a deselect, or no operation. A cycle with neither strobe but with advance asserted continues the access type of the running burst.

Writes go into the array at the capture edge. A global write stores all four 9-bit byte lanes of the 36-bit word. A byte-masked write stores only the lanes whose strobes are low. Read data passes through one output register, so it appears one clock after the read is captured. The output drivers turn off in the cycle right after a deselect is captured, which is one stage earlier than read data would arrive. Output enable and the sleep input gate the drivers without waiting for a clock. While sleep is high the array keeps its contents, and no read or write is taken.

The burst address sequence comes from an external generator on the address port. For a continue cycle, `addr` already carries the next burst address. Actual bus tri-stating happens outside the block: `q_drive` low means the data pins float, and `q_out` then reads zero.

Top module: `sync_burst_ram_ctrl`

## Requirements
- R1: Following a synchronous reset (`rst_n` low at a clock edge), `q_drive` is low and no read data is pending.
- R2: A write cycle with `gw_n` low stores all four byte lanes, whatever `bwe_n` and `bw_n` are.
- R3: A write cycle with `gw_n` high and `bwe_n` low stores exactly the lanes i whose `bw_n[i]` is low. Lane i is bits 9i+8 down to 9i. The other lanes keep their old contents.
- R4: A read captured at edge k puts the word at the captured address on `q_out`, with `q_drive` high, from edge k+1 until edge k+2. This holds provided `oe_n` is low, `sleep` is low, and the command captured at k+1 is not a deselect.
- R5: A deselect captured at edge k drops `q_drive` right after edge k, even while an earlier read's data is in the output register.
- R6: `q_drive` is low whenever `oe_n` is high. Lowering `oe_n` again restores the pending data with no clock edge.
- R7: While `sleep` is high, `q_drive` is low, edges start no read and no write, and the array keeps its contents.
- R8: A processor-strobe cycle (`adsp_n` low) with `ce_n` low is a read, whatever `ce2`, `ce3_n` and the write controls are. With `ce_n` high, the processor strobe is ignored, and the cycle is decoded as if no strobe were present.
- R9: A controller-strobe cycle (`adsc_n` low, `adsp_n` not starting a read) is one of three things. It is a write when `ce_n`=0, `ce2`=1, `ce3_n`=0 and either `gw_n` or `bwe_n` is low. It is a read when those enables hold and both `gw_n` and `bwe_n` are high. It is a deselect when any of the three enables is inactive.
- R10: When both strobes are low and `ce_n` is low, the processor strobe wins, and the cycle is a read even with `gw_n` low.
- R11: A cycle with no strobe and `adv_n` low repeats the running burst's type (read or write) at `addr`. After a deselect or reset, such a cycle accesses nothing. A cycle with no strobe and `adv_n` high is no operation, and `q_drive` falls at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Primary chip enable, active low, qualifies both strobes |
| ce2 | input | 1 | Secondary enable, active high, sampled on controller-strobe cycles |
| ce3_n | input | 1 | Secondary enable, active low, sampled on controller-strobe cycles |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane byte write strobes, active low |
| addr | input | AW (4) | Word address |
| d_in | input | 36 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| q_out | output | 36 | Read data, zero while not driven |
| q_drive | output | 1 | High when the data pins are driven |

## Verification
Writes land at the capture edge, so a read captured on the next edge already sees them. Read data is due one edge after its capture edge. A deselect, `oe_n` and `sleep` take effect on `q_drive` at once: the deselect in the same cycle it is captured, the other two without any edge. The bench sets inputs 2 ns after a rising edge and samples 2 ns after the following one. It compares a burst read's output against the word captured one cycle earlier, and checks deselect, output enable and sleep effects in the cycle they are due. Expected words come from a bench-side model that applies the lane-mask arithmetic of each write.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared command encoding and default geometry of the burst SRAM controller.
// Assumes: every module in the block imports it.
package sram_ctrl_pkg;

    // Decoded action of one captured cycle
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_DESEL = 2'd1,
        CMD_RD    = 2'd2,
        CMD_WR    = 2'd3
    } cmd_e;

    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned LANE_W_DEF = 9;
    localparam int unsigned DEPTH_DEF  = 16;

endpackage

// File: rtl/sram_cmd_decode.sv
// Module: sram_cmd_decode
// Turns the strobes, enables, advance, write controls and sleep of the current
// cycle into one action. It also keeps the type of the running burst, so that
// advance cycles can continue it.
// Assumes: the processor strobe has priority, and sleep forces a no-op.
module sram_cmd_decode
    import sram_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic ce2,
    input  logic ce3_n,
    input  logic adsp_n,
    input  logic adsc_n,
    input  logic adv_n,
    input  logic gw_n,
    input  logic bwe_n,
    input  logic sleep,
    output cmd_e cmd
);

    cmd_e burst_type;
    logic proc_start;
    logic ctrl_enabled;
    logic wr_request;

    // Qualify the strobes and the write request of this cycle
    always_comb begin
        proc_start   = !adsp_n && !ce_n;
        ctrl_enabled = !ce_n && ce2 && !ce3_n;
        wr_request   = !gw_n || !bwe_n;
    end

    // Pick the action for this cycle in priority order
    always_comb begin
        if (sleep) begin
            cmd = CMD_NOP;
        end else if (proc_start) begin
            cmd = CMD_RD;
        end else if (!adsc_n) begin
            if (!ctrl_enabled)   cmd = CMD_DESEL;
            else if (wr_request) cmd = CMD_WR;
            else                 cmd = CMD_RD;
        end else if (!adv_n) begin
            cmd = (burst_type == CMD_RD || burst_type == CMD_WR) ? burst_type : CMD_NOP;
        end else begin
            cmd = CMD_NOP;
        end
    end

    // Track the type of the running burst for advance cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                              burst_type <= CMD_NOP;
        else if (cmd == CMD_RD || cmd == CMD_WR) burst_type <= cmd;
        else if (cmd == CMD_DESEL)               burst_type <= CMD_NOP;
    end

    a_r10_proc_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n && !adsc_n && !sleep) |-> (cmd == CMD_RD));

    a_r7_sleep_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (cmd == CMD_NOP));

endmodule

// File: rtl/sram_byte_mask.sv
// Module: sram_byte_mask
// Builds the per-lane write enables for a write action. Global write covers
// every lane. Otherwise the byte-write enable selects the lanes whose strobe
// is low.
// Assumes: cmd comes from sram_cmd_decode for the same cycle.
module sram_byte_mask
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);

    logic is_write;

    // Flag a write action
    always_comb is_write = (cmd == CMD_WR);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Enable for one lane: global write, or byte-write with the lane strobe low
        always_comb lane_we[g] = is_write && (!gw_n || (!bwe_n && !bw_n[g]));
    end

    a_r2_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (is_write && !gw_n) |-> (&lane_we));

    a_r3_no_lane_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !is_write |-> (lane_we == '0));

endmodule

// File: rtl/sram_lane_array.sv
// Module: sram_lane_array
// The storage, split into one memory per byte lane so that each lane has its
// own write enable. It writes at the clock edge and reads combinationally.
// Assumes: DEPTH is a power of two. The contents have no reset.
module sram_lane_array
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [LANES-1:0] lane_we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane's byte when its enable is set
        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Read this lane's byte at the captured address
        always_comb rd_word[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

    a_r7_sleep_keeps_array: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we == '0));

endmodule

// File: rtl/sram_out_stage.sv
// Module: sram_out_stage
// The one-stage read output register and the gating of the drivers. A captured
// deselect, output enable high or sleep high turns the drivers off.
// Assumes: cmd_q is the action captured at the last edge.
module sram_out_stage
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned DW = LANES_DEF * LANE_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_e          cmd_q,
    input  logic [DW-1:0] rd_word,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [DW-1:0] q_out,
    output logic          q_drive
);

    logic [DW-1:0] data_q;
    logic          valid_q;

    // Load the read word one edge after the read was captured
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= (cmd_q == CMD_RD);
            if (cmd_q == CMD_RD) data_q <= rd_word;
        end
    end

    // Gate the drivers: single-cycle deselect, output enable and sleep
    always_comb begin
        q_drive = valid_q && (cmd_q != CMD_DESEL) && !oe_n && !sleep;
        q_out   = q_drive ? data_q : '0;
    end

endmodule

// File: rtl/sync_burst_ram_ctrl.sv
// Module: sync_burst_ram_ctrl (top)
// A pipelined burst SRAM: decode, lane write mask, array, capture registers and
// output stage. Writes take effect at the capture edge. Read data follows one
// edge later.
// Assumes: the external burst generator drives the continue addresses on addr.
module sync_burst_ram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    d_in,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [DW-1:0]    q_out,
    output logic             q_drive
);

    cmd_e             cmd;
    cmd_e             cmd_q;
    logic [AW-1:0]    addr_q;
    logic [LANES-1:0] lane_we;
    logic [DW-1:0]    rd_word;

    sram_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .sleep(sleep), .cmd(cmd)
    );

    sram_byte_mask #(.LANES(LANES)) u_mask (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .lane_we(lane_we)
    );

    sram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_arr (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .lane_we(lane_we),
        .wr_addr(addr), .wr_data(d_in), .rd_addr(addr_q), .rd_word(rd_word)
    );

    // Capture the decoded action and its address at the edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
        end else begin
            cmd_q  <= cmd;
            addr_q <= addr;
        end
    end

    sram_out_stage #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .cmd_q(cmd_q), .rd_word(rd_word),
        .oe_n(oe_n), .sleep(sleep), .q_out(q_out), .q_drive(q_drive)
    );

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !q_drive);

    a_r5_deselect_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !sleep && !adsc_n && ce_n) |-> !q_drive);

    a_r6_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_drive);

endmodule

// File: tb/sim_sync_burst_ram_ctrl.sv
// Bench for sync_burst_ram_ctrl. It sets inputs 2 ns after a rising edge and
// samples 2 ns after the next one, against a bench-side memory model.
module sim_sync_burst_ram_ctrl;

    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int DW    = 36;

    logic          clk = 1'b0;
    logic          rst_n, ce_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, sleep;
    logic [3:0]    bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in;
    logic [DW-1:0] q_out;
    logic          q_drive;

    logic [DW-1:0] model [DEPTH];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sync_burst_ram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .addr(addr), .d_in(d_in), .oe_n(oe_n), .sleep(sleep),
        .q_out(q_out), .q_drive(q_drive)
    );

    function automatic logic [DW-1:0] pat(input int i);
        logic [DW-1:0] v;
        v = DW'(i) * 36'h0_1234_5679;
        return v ^ 36'h9_A5A5_A5A5;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, new_w,
                                            input logic [3:0] strobes_n);
        logic [DW-1:0] r;
        r = old_w;
        for (int l = 0; l < 4; l++)
            if (!strobes_n[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in();
        ce_n = 1; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF; addr = '0; d_in = '0;
    endtask

    // Processor-strobe read; secondary enables and write controls set to the "wrong" values
    task automatic rd_p(input int a);
        idle_in(); ce_n = 0; ce2 = 0; ce3_n = 1; adsp_n = 0; gw_n = 0; bwe_n = 0;
        addr = AW'(a); tick();
    endtask

    task automatic rd_c(input int a);
        idle_in(); ce_n = 0; adsc_n = 0; addr = AW'(a); tick();
    endtask

    task automatic wr_c(input int a, input logic [DW-1:0] d, input logic g, b, input logic [3:0] m);
        idle_in(); ce_n = 0; adsc_n = 0; gw_n = g; bwe_n = b; bw_n = m;
        addr = AW'(a); d_in = d; tick();
    endtask

    task automatic cont(input int a, input logic [DW-1:0] d, input logic g);
        idle_in(); adv_n = 0; gw_n = g; addr = AW'(a); d_in = d; tick();
    endtask

    task automatic nop();
        idle_in(); tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_in(); oe_n = 0; sleep = 0; rst_n = 0;
        repeat (4) tick();
        chk("R1 drive after reset", 36'(q_drive), 36'd0);
        rst_n = 1;
        nop();
        chk("R1 drive idle", 36'(q_drive), 36'd0);
        // R11 after reset: an advance with no burst accesses nothing
        cont(2, '0, 1'b1); nop();
        chk("R11 adv after reset", 36'(q_drive), 36'd0);

        // R2 + R11: global-write burst fills the array, byte controls set to a partial mask
        idle_in(); ce_n = 0; adsc_n = 0; gw_n = 0; bwe_n = 0; bw_n = 4'b0101;
        addr = 0; d_in = pat(0); tick(); model[0] = pat(0);
        for (int i = 1; i < DEPTH; i++) begin
            cont(i, pat(i), 1'b0); model[i] = pat(i);
        end

        // R4 + R8 + R11: processor-strobe burst read, one-cycle latency
        rd_p(0);
        for (int i = 1; i < DEPTH; i++) begin
            idle_in(); adv_n = 0; addr = AW'(i); tick();
            chk("R4 burst read data", q_out, model[i-1]);
            chk("R4 burst read drive", 36'(q_drive), 36'd1);
        end
        nop();
        chk("R11 last burst word", q_out, model[DEPTH-1]);
        nop();
        chk("R11 suspend releases", 36'(q_drive), 36'd0);

        // R3: every lane mask under byte-write, then R9 read back via controller strobe
        for (int m = 0; m < 16; m++) begin
            wr_c(m, ~pat(m + 40), 1'b1, 1'b0, 4'(m));
            model[m] = merge(model[m], ~pat(m + 40), 4'(m));
        end
        for (int m = 0; m < 16; m++) begin
            rd_c(m); nop();
            chk("R3 lane mask readback", q_out, model[m]);
        end
        // R3: byte-write enable high with global write high stores nothing (read instead)
        wr_c(7, pat(99), 1'b1, 1'b1, 4'h0); nop();
        chk("R9 no write enables means read", q_out, model[7]);

        // R2: global write overrides all-high lane strobes
        wr_c(3, pat(77), 1'b0, 1'b1, 4'hF); model[3] = pat(77);
        rd_c(3); nop();
        chk("R2 global write all lanes", q_out, model[3]);

        // R5: deselect right after a read cuts the drivers at once
        rd_c(4);
        idle_in(); adsc_n = 0; ce_n = 1; tick();
        chk("R5 desel ce_n", 36'(q_drive), 36'd0);
        rd_c(4);
        idle_in(); adsc_n = 0; ce_n = 0; ce2 = 0; tick();
        chk("R9 desel ce2 low", 36'(q_drive), 36'd0);
        rd_c(4);
        idle_in(); adsc_n = 0; ce_n = 0; ce3_n = 1; d_in = pat(5); gw_n = 0; addr = 4; tick();
        chk("R9 desel ce3_n high", 36'(q_drive), 36'd0);
        rd_c(4); nop();
        chk("R9 deselect did not write", q_out, model[4]);
        // R11: advance after a deselect does nothing
        idle_in(); adsc_n = 0; ce_n = 1; tick();
        cont(6, pat(3), 1'b0); nop();
        chk("R11 adv after desel", 36'(q_drive), 36'd0);
        rd_c(6); nop();
        chk("R11 adv after desel no write", q_out, model[6]);

        // R8: processor strobe with ce_n high is ignored
        idle_in(); adsp_n = 0; ce_n = 1; addr = 2; tick(); nop();
        chk("R8 ignored strobe", 36'(q_drive), 36'd0);

        // R10: both strobes low, global write low: it is a read
        idle_in(); ce_n = 0; adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 9; d_in = pat(123); tick();
        nop();
        chk("R10 priority read data", q_out, model[9]);
        rd_c(9); nop();
        chk("R10 no write happened", q_out, model[9]);

        // R6: output enable gates asynchronously
        rd_c(10); oe_n = 1; nop(); oe_n = 1;
        chk("R6 oe high drive", 36'(q_drive), 36'd0);
        #1 oe_n = 0; #1;
        chk("R6 oe low drive", 36'(q_drive), 36'd1);
        chk("R6 oe low data", q_out, model[10]);

        // R7: sleep drops the drivers at once and blocks a write
        sleep = 1; #1;
        chk("R7 sleep drive", 36'(q_drive), 36'd0);
        wr_c(5, pat(200), 1'b0, 1'b0, 4'h0);
        rd_c(5);
        sleep = 0;
        nop();
        chk("R7 sleep read blocked", 36'(q_drive), 36'd0);
        rd_c(5); nop();
        chk("R7 contents kept", q_out, model[5]);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule